// File: doc/BRIEF.md
# Polarity-Steered Bit-Slice ALU

This block is the combinational arithmetic and logic unit for the data-processing instructions of a small RISC core. A 4-bit opcode picks one of sixteen operations. Operand A comes from a register read port and operand B from the shifter output. The block returns a result word, a carry flag and a zero flag. The shifter, the register file, the sign and overflow flags, and flag write-back are all outside this block.

There is no separate adder, AND, OR or XOR unit and no result multiplexer. A small decoder turns the opcode into a handful of polarity controls. One identical slice, repeated once per bit, uses these controls to build every operation. The controls do four things: they re-invert operand A (which reaches the slice in complement form), they steer B or its complement onto an upper path and a lower path, they open or close the carry chain, and they set the carry into bit 0. Each slice hands carry and zero to its neighbour in inverted polarity, so even and odd slices use complementary logic. The top module puts both flags back into true polarity.

The ADC, SBC and RSC operations take their carry from an incoming carry flag. The test and compare operations return the same word and flags as the logic or arithmetic operation they mirror.

Top module: `pol_alu`

## Requirements
- R1: The opcode encodings are AND=0, EOR=1, SUB=2, RSB=3, ADD=4, ADC=5, SBC=6, RSC=7, TST=8, TEQ=9, CMP=10, CMN=11, ORR=12, MOV=13, BIC=14, MVN=15. AND gives A&B, EOR gives A^B, ORR gives A|B and BIC gives A&~B.
- R2: MOV gives B and MVN gives ~B. Operand A has no effect on either.
- R3: ADD gives {carry,result} = A+B. ADC gives {carry,result} = A+B+carry_flag_in.
- R4: SUB gives A-B and RSB gives B-A, each computed as an add of the complement plus 1. Carry is 1 exactly when no borrow occurs.
- R5: SBC gives A+~B+carry_flag_in and RSC gives ~A+B+carry_flag_in. Carry is the carry out of the top bit.
- R6: TST, TEQ, CMP and CMN give the same result and flags as AND, EOR, SUB and ADD.
- R7: zero_out is 1 exactly when every result bit is 0.
- R8: carry_out is 0 for every logical operation (opcodes 0, 1, 8, 9, 12, 13, 14, 15).
- R9: carry_flag_in has no effect on any operation other than ADC, SBC and RSC.
- R10: For any WIDTH of 2 or more, odd or even, the result and both flags follow R1 to R9 at that width, and the flags come out in true polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | Operand A (register read port) |
| op_b | input | WIDTH | Operand B (shifter output) |
| opcode | input | 4 | Operation select |
| carry_flag_in | input | 1 | Current carry flag, used by ADC/SBC/RSC |
| result | output | WIDTH | Operation result |
| carry_out | output | 1 | Carry out of the top bit, 0 for logical operations |
| zero_out | output | 1 | High when result is all zeros |

## Verification
The bench builds two copies of the block. One uses the default WIDTH of 32. The other uses WIDTH of 7, so the top slice there is even-numbered and the inverted-polarity output path is exercised. Both copies get the same opcodes, corner operands (0, all ones, the top bit alone, the top bit clear, one) under both carry-flag values, plus random operands. The narrow copy also makes carry and zero cases common enough to cover well, such as wrap-around to zero and borrow at the top bit.

// File: rtl/pol_alu_pkg.sv
package pol_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  // Per-operation slice controls.
  typedef struct packed {
    logic keep_a;    // 1: re-invert the complemented operand A to true form
    logic up_true;   // upper path passes B
    logic up_comp;   // upper path passes ~B
    logic lo_blk_t;  // 1 blocks B from the lower path
    logic lo_blk_c;  // 1 blocks ~B from the lower path
    logic chain_en;  // carry chain open (arithmetic only)
    logic cin;       // carry into bit 0
  } slice_ctl_t;

endpackage

// File: rtl/pol_alu_dec.sv
module pol_alu_dec
  import pol_alu_pkg::*;
(
  input  logic [3:0]  opcode,
  input  logic        carry_flag_in,
  output slice_ctl_t  ctl
);

  // Path shorthands: "add" form has upper=~y, lower=y, where y is the
  // addend seen by the chain.
  always_comb begin
    ctl = '0;
    case (opcode)
      OP_AND, OP_TST: begin
        ctl.keep_a = 1'b1; ctl.up_true = 1'b1;
        ctl.lo_blk_t = 1'b1; ctl.lo_blk_c = 1'b1;
      end
      OP_BIC: begin
        ctl.keep_a = 1'b1; ctl.up_comp = 1'b1;
        ctl.lo_blk_t = 1'b1; ctl.lo_blk_c = 1'b1;
      end
      OP_EOR, OP_TEQ: begin
        ctl.keep_a = 1'b1; ctl.up_comp = 1'b1; ctl.lo_blk_c = 1'b1;
      end
      OP_ORR: begin
        ctl.keep_a = 1'b1; ctl.up_true = 1'b1; ctl.up_comp = 1'b1;
        ctl.lo_blk_c = 1'b1;
      end
      OP_MOV: begin
        ctl.keep_a = 1'b1; ctl.up_true = 1'b1; ctl.lo_blk_c = 1'b1;
      end
      OP_MVN: begin
        ctl.keep_a = 1'b1; ctl.up_comp = 1'b1; ctl.lo_blk_t = 1'b1;
      end
      OP_ADD, OP_CMN, OP_ADC: begin
        ctl.keep_a = 1'b1; ctl.up_comp = 1'b1; ctl.lo_blk_c = 1'b1;
        ctl.chain_en = 1'b1;
        ctl.cin = (opcode == OP_ADC) ? carry_flag_in : 1'b0;
      end
      OP_SUB, OP_CMP, OP_SBC: begin
        ctl.keep_a = 1'b1; ctl.up_true = 1'b1; ctl.lo_blk_t = 1'b1;
        ctl.chain_en = 1'b1;
        ctl.cin = (opcode == OP_SBC) ? carry_flag_in : 1'b1;
      end
      OP_RSB, OP_RSC: begin
        ctl.keep_a = 1'b0; ctl.up_comp = 1'b1; ctl.lo_blk_c = 1'b1;
        ctl.chain_en = 1'b1;
        ctl.cin = (opcode == OP_RSC) ? carry_flag_in : 1'b1;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/pol_alu_slice.sv
module pol_alu_slice
  import pol_alu_pkg::*;
#(
  parameter bit ODD = 1'b0  // odd slices take inverted chain inputs
)(
  input  logic       a_n,   // operand A bit, complemented
  input  logic       b,
  input  slice_ctl_t ctl,
  input  logic       cy_i,  // true polarity on even slices, inverted on odd
  input  logic       z_i,   // same polarity rule as cy_i
  output logic       res,
  output logic       cy_o,  // opposite polarity to cy_i
  output logic       z_o
);

  logic a1, up, lo, cy_t, z_t, c_eff, gen, zlo;

  generate
    if (ODD) begin : g_in_inv
      assign cy_t = ~cy_i;
      assign z_t  = ~z_i;
    end else begin : g_in_true
      assign cy_t = cy_i;
      assign z_t  = z_i;
    end
  endgenerate

  always_comb begin
    a1    = ctl.keep_a ? ~a_n : a_n;
    up    = (ctl.up_true & b) | (ctl.up_comp & ~b);
    lo    = (~ctl.lo_blk_t & b) | (~ctl.lo_blk_c & ~b);
    c_eff = ctl.chain_en & cy_t;
    res   = (a1 ? up : lo) ^ c_eff;
    gen   = ctl.chain_en & (a1 ? (lo | cy_t) : (lo & cy_t));
    zlo   = z_t & ~res;
  end

  generate
    if (ODD) begin : g_out_true
      assign cy_o = gen;
      assign z_o  = zlo;
    end else begin : g_out_inv
      assign cy_o = ~gen;
      assign z_o  = ~zlo;
    end
  endgenerate

endmodule

// File: rtl/pol_alu.sv
module pol_alu
  import pol_alu_pkg::*;
#(
  parameter int WIDTH = 32
)(
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [3:0]       opcode,
  input  logic             carry_flag_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             zero_out
);

  localparam bit TOP_ODD = ((WIDTH - 1) % 2) == 1;

  slice_ctl_t       ctl;
  logic [WIDTH-1:0] a_n;
  logic [WIDTH:0]   cy;
  logic [WIDTH:0]   zc;

  pol_alu_dec u_dec (
    .opcode        (opcode),
    .carry_flag_in (carry_flag_in),
    .ctl           (ctl)
  );

  // Operand A enters the slices complemented, as from an inverting read port.
  assign a_n   = ~op_a;
  assign cy[0] = ctl.cin;
  assign zc[0] = 1'b1;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      pol_alu_slice #(.ODD((i % 2) == 1)) u_slice (
        .a_n  (a_n[i]),
        .b    (op_b[i]),
        .ctl  (ctl),
        .cy_i (cy[i]),
        .z_i  (zc[i]),
        .res  (result[i]),
        .cy_o (cy[i+1]),
        .z_o  (zc[i+1])
      );
    end

    if (TOP_ODD) begin : g_flags_true
      assign carry_out = cy[WIDTH];
      assign zero_out  = zc[WIDTH];
    end else begin : g_flags_fix
      assign carry_out = ~cy[WIDTH];
      assign zero_out  = ~zc[WIDTH];
    end
  endgenerate

endmodule

// File: rtl/pol_alu_chk.sv
module pol_alu_chk #(
  parameter int WIDTH = 32
)(
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [3:0]       opcode,
  input logic             carry_flag_in,
  input logic [WIDTH-1:0] result,
  input logic             carry_out,
  input logic             zero_out
);

  logic logical_op;
  assign logical_op = (opcode == 4'd0) || (opcode == 4'd1) || (opcode == 4'd8) ||
                      (opcode == 4'd9) || (opcode >= 4'd12);

  always_comb begin
    if (!$isunknown({op_a, op_b, opcode, carry_flag_in, result, carry_out, zero_out})) begin
      p_zero_flag_r7: assert (zero_out == (result == '0));
      if (logical_op) begin
        p_logic_nocarry_r8: assert (carry_out == 1'b0);
      end
      if (opcode == 4'd4 || opcode == 4'd11) begin
        p_add_sum_r3: assert ({carry_out, result} == ({1'b0, op_a} + {1'b0, op_b}));
      end
      if (opcode == 4'd2 || opcode == 4'd10) begin
        p_sub_diff_r4: assert (result == op_a - op_b && carry_out == (op_a >= op_b));
      end
      if (opcode == 4'd13) begin
        p_mov_pass_r2: assert (result == op_b);
      end
    end
  end

endmodule

bind pol_alu pol_alu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/pol_alu_test.sv
module pol_alu_test;

  localparam int W  = 32;
  localparam int WS = 7;

  logic clk, rst_n;
  logic [W-1:0] a, b;
  logic [3:0]   op;
  logic         cf;
  logic [W-1:0]  res;  logic c, z;
  logic [WS-1:0] res_s; logic c_s, z_s;

  int checks = 0, errors = 0;
  bit done = 0;

  initial clk = 0;
  always #4 clk = ~clk;  // 125 MHz

  pol_alu #(.WIDTH(W)) uut (
    .op_a(a), .op_b(b), .opcode(op), .carry_flag_in(cf),
    .result(res), .carry_out(c), .zero_out(z));

  pol_alu #(.WIDTH(WS)) uut_odd (
    .op_a(a[WS-1:0]), .op_b(b[WS-1:0]), .opcode(op), .carry_flag_in(cf),
    .result(res_s), .carry_out(c_s), .zero_out(z_s));

  typedef struct {
    string       tag;
    bit          logical;
    logic [31:0] r;  logic rc, rz;
    logic [31:0] rs; logic rcs, rzs;
  } item_t;

  item_t sb[$];

  // Reference: returns {zero, carry, result} at width w.
  function automatic logic [33:0] model(input logic [3:0] o, input logic [31:0] x,
                                        input logic [31:0] y, input logic ci, input int w);
    logic [63:0] m, ux, uy, r;
    logic cc;
    m  = (64'd1 << w) - 1;
    ux = {32'd0, x} & m;
    uy = {32'd0, y} & m;
    cc = 1'b0;
    case (o)
      4'd0, 4'd8:  r = ux & uy;
      4'd1, 4'd9:  r = ux ^ uy;
      4'd12:       r = ux | uy;
      4'd13:       r = uy;
      4'd14:       r = ux & ~uy & m;
      4'd15:       r = ~uy & m;
      4'd4, 4'd11: r = ux + uy;
      4'd5:        r = ux + uy + {63'd0, ci};
      4'd2, 4'd10: r = ux + (~uy & m) + 64'd1;
      4'd3:        r = (~ux & m) + uy + 64'd1;
      4'd6:        r = ux + (~uy & m) + {63'd0, ci};
      default:     r = (~ux & m) + uy + {63'd0, ci};
    endcase
    if (o inside {[4'd2:4'd7], 4'd10, 4'd11}) cc = r[w];
    r = r & m;
    return {(r == 64'd0), cc, r[31:0]};
  endfunction

  function automatic string tag_of(input logic [3:0] o, input logic ci);
    if (ci && !(o inside {4'd5, 4'd6, 4'd7})) return "R9";
    case (o)
      4'd0, 4'd1, 4'd12, 4'd14: return "R1";
      4'd13, 4'd15:             return "R2";
      4'd4, 4'd5:               return "R3";
      4'd2, 4'd3:               return "R4";
      4'd6, 4'd7:               return "R5";
      default:                  return "R6";
    endcase
  endfunction

  task automatic drive(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                       input logic ci, input string tg);
    item_t it;
    logic [33:0] e, es;
    @(posedge clk); #1;
    op = o; a = x; b = y; cf = ci;
    e  = model(o, x, y, ci, W);
    es = model(o, x, y, ci, WS);
    it.tag = (tg == "") ? tag_of(o, ci) : tg;
    it.logical = (o inside {4'd0, 4'd1, 4'd8, 4'd9, [4'd12:4'd15]});
    it.r  = e[31:0];  it.rc  = e[32];  it.rz  = e[33];
    it.rs = es[31:0]; it.rcs = es[32]; it.rzs = es[33];
    sb.push_back(it);
  endtask

  task automatic chk(input string tg, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s op=%0d a=%h b=%h cf=%0d actual=%h expected=%h",
               tg, what, op, a, b, cf, act, exp);
    end
  endtask

  // Monitor: compares at the falling edge, after inputs settle.
  always @(negedge clk) begin
    if (rst_n && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      chk(it.tag, res, it.r, "result");
      chk(it.logical ? "R8" : it.tag, {31'd0, c}, {31'd0, it.rc}, "carry");
      chk("R7", {31'd0, z}, {31'd0, it.rz}, "zero");
      chk("R10", {25'd0, res_s}, it.rs, "narrow result");
      chk("R10", {31'd0, c_s}, {31'd0, it.rcs}, "narrow carry");
      chk("R10", {31'd0, z_s}, {31'd0, it.rzs}, "narrow zero");
    end
  end

  initial begin
    logic [31:0] corner [5];
    corner[0] = 32'h0000_0000; corner[1] = 32'hFFFF_FFFF; corner[2] = 32'h8000_0000;
    corner[3] = 32'h7FFF_FFFF; corner[4] = 32'h0000_0001;
    rst_n = 0; op = 4'd0; a = '0; b = '0; cf = 0;
    repeat (3) @(posedge clk);
    // Reset-time state with zero inputs: AND of zeros gives zero, no carry (R7, R8).
    @(negedge clk);
    chk("R7", {31'd0, z}, 32'd1, "idle zero");
    chk("R8", {31'd0, c}, 32'd0, "idle carry");
    chk("R1", res, 32'd0, "idle result");
    rst_n = 1;
    // R2: MOV/MVN with operand A varied, B fixed.
    for (int k = 0; k < 8; k++) begin
      drive(4'd13, $urandom, 32'h1234_5678, 1'b0, "R2");
      drive(4'd15, $urandom, 32'h1234_5678, 1'b0, "R2");
    end
    // R4 boundaries: equal operands give zero and carry set.
    drive(4'd2, 32'h8000_0000, 32'h8000_0000, 1'b0, "R4");
    drive(4'd3, 32'd0, 32'd1, 1'b0, "R4");
    drive(4'd4, 32'hFFFF_FFFF, 32'd1, 1'b0, "R3");
    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          for (int ci = 0; ci < 2; ci++)
            drive(o[3:0], corner[i], corner[j], ci[0], "");
    for (int o = 0; o < 16; o++)
      for (int k = 0; k < 150; k++)
        drive(o[3:0], $urandom, $urandom, 1'($urandom), "");
    repeat (3) @(posedge clk);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule